// File: doc/BRIEF.md
# External Bus Cycle Timing Controller

This block drives the control strobes for a single external memory access. A request arrives with an address, a direction and a fetch flag. The block first raises the address latch enable. It then pulls down exactly one active-low strobe: program fetch, data read or data write. It holds that strobe for a base period plus a number of wait states. One clock period of the block equals one oscillator period.

The wait-state count comes from one of two static 2-bit codes. The codes are inverted: a lower code gives more wait states. The address region, taken from address bits [23:16], selects which code applies. A third static bit, active low, stretches the address latch enable from one period to three so that a slow external latch can keep up.

All configuration is captured when a request is accepted. A request is accepted only while the block is not busy. A one-clock done pulse marks the end of each access.

Top module: `ext_bus_timer`

## Requirements
- R1: When `req_i` is high and `busy_o` is low at a clock edge, the request is accepted. From the next cycle, `ale_o` and `busy_o` are high. `busy_o` stays high until the done cycle has ended.
- R2: `ale_o` stays high for 3 consecutive cycles when `ale_stretch_ni` is 0 at acceptance, and for 1 cycle when it is 1.
- R3: A wait code maps to wait states as 2'b00→3, 2'b01→2, 2'b10→1 and 2'b11→0. The strobe stays low for 1 plus that number of cycles.
- R4: When address bits [23:16] equal 8'h01, the code on `ws_b_ni` applies. Every other region, including 8'h00, 8'hFE and 8'hFF, uses `ws_a_ni`.
- R5: Exactly one strobe goes low in the strobe phase. It is `psen_no` when `fetch_i` is 1, whatever `write_i` is. Otherwise it is `wr_no` when `write_i` is 1, and `rd_no` when `write_i` is 0. No strobe is low while `ale_o` is high or while the block is idle.
- R6: The strobe goes low in the cycle right after the last `ale_o` cycle.
- R7: `done_o` is high for exactly one cycle, the one right after the strobe returns high. `busy_o` is low in the following cycle.
- R8: A request raised while `busy_o` is high is ignored. It produces no access and does not change the access in progress.
- R9: Changes to `ale_stretch_ni`, `ws_a_ni` or `ws_b_ni` after acceptance do not affect the access in progress.
- R10: After reset, `ale_o` and `done_o` are low, `busy_o` is low, and all three strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| addr_i | input | 24 | Access address; bits [23:16] give the region |
| write_i | input | 1 | 1 for a data write, 0 for a data read |
| fetch_i | input | 1 | 1 for a program fetch |
| ale_stretch_ni | input | 1 | 0 gives a 3-cycle ALE, 1 gives a 1-cycle ALE |
| ws_a_ni | input | 2 | Inverted wait code for regions other than 8'h01 |
| ws_b_ni | input | 2 | Inverted wait code for region 8'h01 |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| psen_no | output | 1 | Program fetch strobe, active low |
| done_o | output | 1 | One-cycle end-of-access pulse |
| busy_o | output | 1 | Access in progress |

## Verification
Reads, writes and fetches are issued across regions 8'h00, 8'h01, 8'h37, 8'hFE and 8'hFF. The two wait codes are always set to different values, so a wrong region choice shows up as a wrong strobe width. Every code is swept on both fields, which separates the inverted mapping from a direct one. Fetches are issued with `write_i` also high, so the fetch priority is tested. The ALE stretch is tried in both settings. Some configuration changes are made right after acceptance, and some requests are raised during a busy access. These show whether values are captured at acceptance and whether the busy gate holds.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
  localparam int ADDR_W    = 24;
  localparam int REGION_W  = 8;
  localparam int WS_W      = 2;
  localparam int ALE_SHORT = 1;
  localparam int ALE_LONG  = 3;
  localparam int WS_MAX    = (1 << WS_W) - 1;
  localparam int CNT_MAX   = (ALE_LONG > WS_MAX) ? ALE_LONG : WS_MAX;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ALE, ST_STB, ST_DONE} ebt_state_e;
  typedef enum logic [1:0] {K_READ, K_WRITE, K_FETCH} ebt_kind_e;
endpackage

// File: rtl/ebt_wait_sel.sv
module ebt_wait_sel
  import ebt_pkg::*;
#(
  parameter int                RGN_W    = REGION_W,
  parameter int                CODE_W   = WS_W,
  parameter logic [RGN_W-1:0]  REGION_B = 8'h01
) (
  input  logic [RGN_W-1:0]  region_i,
  input  logic [CODE_W-1:0] ws_a_ni,
  input  logic [CODE_W-1:0] ws_b_ni,
  output logic [CODE_W-1:0] ws_o
);
  logic [CODE_W-1:0] code_n;

  always_comb begin
    code_n = (region_i == REGION_B) ? ws_b_ni : ws_a_ni;
    ws_o   = ~code_n;  // inverted code: 00 -> max waits
  end
endmodule

// File: rtl/ebt_seq.sv
module ebt_seq
  import ebt_pkg::*;
#(
  parameter int CODE_W = WS_W,
  parameter int CW     = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              write_i,
  input  logic              fetch_i,
  input  logic              ale_stretch_ni,
  input  logic [CODE_W-1:0] ws_i,
  output ebt_state_e        state_o,
  output ebt_kind_e         kind_o
);
  ebt_state_e        state_q;
  ebt_kind_e         kind_q;
  logic [CODE_W-1:0] ws_q;
  logic [CW-1:0]     cnt_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= K_READ;
      ws_q    <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ALE;
          ws_q    <= ws_i;
          kind_q  <= fetch_i ? K_FETCH : (write_i ? K_WRITE : K_READ);
          cnt_q   <= ale_stretch_ni ? CW'(ALE_SHORT - 1) : CW'(ALE_LONG - 1);
        end
        ST_ALE: if (cnt_q == '0) begin
          state_q <= ST_STB;
          cnt_q   <= CW'(ws_q);  // extra periods beyond base
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_STB: if (cnt_q == '0) state_q <= ST_DONE;
                else cnt_q <= cnt_q - 1'b1;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign kind_o  = kind_q;

  AST_ACCEPT_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i) |=> (state_q == ST_ALE)); // R1
  AST_ALE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && ale_stretch_ni) |=> (state_q == ST_ALE) ##1 (state_q == ST_STB)); // R2
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(ws_q) && $stable(kind_q))); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STB && req_i) |=> (state_q != ST_ALE)); // R8
  AST_DONE_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE)); // R7
endmodule

// File: rtl/ebt_strobes.sv
module ebt_strobes
  import ebt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ebt_state_e state_i,
  input  ebt_kind_e  kind_i,
  output logic       ale_o,
  output logic       rd_no,
  output logic       wr_no,
  output logic       psen_no,
  output logic       done_o,
  output logic       busy_o
);
  logic stb_on;

  always_comb begin
    stb_on  = (state_i == ST_STB);
    ale_o   = (state_i == ST_ALE);
    done_o  = (state_i == ST_DONE);
    busy_o  = (state_i != ST_IDLE);
    rd_no   = !(stb_on && kind_i == K_READ);
    wr_no   = !(stb_on && kind_i == K_WRITE);
    psen_no = !(stb_on && kind_i == K_FETCH);
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rd_no, wr_no, psen_no}) >= 2); // R5
  AST_ALE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no && psen_no)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!(rd_no && wr_no && psen_no))); // R7
endmodule

// File: rtl/ext_bus_timer.sv
module ext_bus_timer
  import ebt_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int RGN_W  = REGION_W,
  parameter int CODE_W = WS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              write_i,
  input  logic              fetch_i,
  input  logic              ale_stretch_ni,
  input  logic [CODE_W-1:0] ws_a_ni,
  input  logic [CODE_W-1:0] ws_b_ni,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              psen_no,
  output logic              done_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] ws;
  ebt_state_e        state;
  ebt_kind_e         kind;

  ebt_wait_sel #(.RGN_W(RGN_W), .CODE_W(CODE_W)) u_wait_sel (
    .region_i (addr_i[AW-1 -: RGN_W]),
    .ws_a_ni  (ws_a_ni),
    .ws_b_ni  (ws_b_ni),
    .ws_o     (ws)
  );

  ebt_seq #(.CODE_W(CODE_W)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_i),
    .write_i        (write_i),
    .fetch_i        (fetch_i),
    .ale_stretch_ni (ale_stretch_ni),
    .ws_i           (ws),
    .state_o        (state),
    .kind_o         (kind)
  );

  ebt_strobes u_strobes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .kind_i  (kind),
    .ale_o   (ale_o),
    .rd_no   (rd_no),
    .wr_no   (wr_no),
    .psen_no (psen_no),
    .done_o  (done_o),
    .busy_o  (busy_o)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> (busy_o && ale_o)); // R1
  AST_STB_AFTER_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> !(rd_no && wr_no && psen_no)); // R6
endmodule

// File: tb/ext_bus_timer_tb.sv
module ext_bus_timer_tb_top;
  localparam time CLK_P = 8ns;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, write = 0, fetch = 0, ale_n = 1;
  logic [23:0] addr = '0;
  logic [1:0]  wsa = 2'b11, wsb = 2'b11;
  logic        ale, rd_n, wr_n, psen_n, done, busy;

  int total = 0, bad = 0, issued = 0, seen = 0;
  bit ended = 0;
  int q_ale[$], q_stb[$], q_kind[$];
  string q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  ext_bus_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .write_i(write),
    .fetch_i(fetch), .ale_stretch_ni(ale_n), .ws_a_ni(wsa), .ws_b_ni(wsb),
    .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n), .psen_no(psen_n),
    .done_o(done), .busy_o(busy)
  );

  task automatic chk(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: issue one access and push its expectation
  task automatic issue(logic [23:0] a, bit w, bit f, bit xn, logic [1:0] a_n,
                       logic [1:0] b_n, string tag);
    logic [1:0] code;
    while (busy) @(negedge clk);
    addr = a; write = w; fetch = f; ale_n = xn; wsa = a_n; wsb = b_n; req = 1;
    code = (a[23:16] == 8'h01) ? b_n : a_n;
    q_ale.push_back(xn ? 1 : 3);
    q_stb.push_back(1 + (3 - int'(code)));
    q_kind.push_back(f ? 2 : (w ? 1 : 0));
    q_tag.push_back(tag);
    issued++;
    @(negedge clk);
    req = 0;
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  int  ale_cnt = 0, stb_cnt = 0, stb_kind = -1;
  bit  prev_ale = 0, prev_low = 0, after_done = 0;
  always @(negedge clk) if (rst_n && !ended) begin
    int lows;
    lows = int'(!rd_n) + int'(!wr_n) + int'(!psen_n);
    if (after_done) begin
      chk(!busy, "R7 busy after done", busy, 0);
      after_done = 0;
    end
    if (ale) begin
      ale_cnt++;
      chk(lows == 0, "R5 strobe during ALE", lows, 0);
    end
    if (lows > 0) begin
      chk(lows == 1, "R5 one strobe", lows, 1);
      if (!prev_low) chk(prev_ale, "R6 strobe follows ALE", prev_ale, 1);
      stb_cnt++;
      stb_kind = !rd_n ? 0 : (!wr_n ? 1 : 2);
    end
    if (!busy) chk(lows == 0 && !ale, "R5 idle quiet", lows, 0);
    if (done) begin
      seen++;
      chk(prev_low && lows == 0, "R7 done after strobe", prev_low, 1);
      if (q_ale.size() == 0) chk(0, "R8 unexpected access", seen, issued);
      else begin
        string t;
        int ea, es, ek;
        t = q_tag.pop_front(); ea = q_ale.pop_front();
        es = q_stb.pop_front(); ek = q_kind.pop_front();
        chk(ale_cnt == ea, {t, " ALE length"}, ale_cnt, ea);
        chk(stb_cnt == es, {t, " strobe width"}, stb_cnt, es);
        chk(stb_kind == ek, {t, " strobe kind"}, stb_kind, ek);
      end
      ale_cnt = 0; stb_cnt = 0; stb_kind = -1; after_done = 1;
    end
    if (prev_low && lows == 0) chk(done, "R7 done timing", done, 1);
    prev_ale = ale; prev_low = (lows > 0);
  end

  initial begin
    #(CLK_P * 150000);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    #(CLK_P * 3);
    @(negedge clk);
    // R10 reset state
    chk(!ale, "R10 ale", ale, 0);
    chk(rd_n && wr_n && psen_n, "R10 strobes", {rd_n, wr_n, psen_n}, 7);
    chk(!done, "R10 done", done, 0);
    chk(!busy, "R10 busy", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !ale, "R10 idle after release", busy, 0);

    // R1 acceptance
    issue(24'h00_1234, 0, 0, 1, 2'b11, 2'b00, "R1 R3 read r00");
    chk(busy && ale, "R1 busy+ale after accept", {busy, ale}, 3);
    drain();
    issue(24'h00_0010, 1, 0, 1, 2'b00, 2'b11, "R3 write r00 ws3");
    drain();
    issue(24'hFF_0000, 1, 1, 1, 2'b01, 2'b11, "R4 R5 fetch rFF");
    drain();
    issue(24'h01_8000, 0, 0, 1, 2'b00, 2'b10, "R4 read r01");
    drain();
    issue(24'hFE_0004, 1, 0, 0, 2'b10, 2'b00, "R2 write rFE long ale");
    drain();
    issue(24'h37_0000, 0, 0, 1, 2'b11, 2'b00, "R4 read r37");
    drain();

    // R9 config change after acceptance
    issue(24'h01_0002, 0, 1, 1, 2'b11, 2'b00, "R9 fetch r01");
    ale_n = 0; wsb = 2'b11; wsa = 2'b00;
    drain();

    // R8 request while busy
    issue(24'h00_0000, 0, 0, 0, 2'b11, 2'b00, "R8 read r00");
    addr = 24'h01_0000; write = 1; wsb = 2'b00; req = 1;
    @(negedge clk); @(negedge clk);
    req = 0;
    drain();
    chk(seen == issued, "R8 access count", seen, issued);

    // R3 code sweep on both fields
    for (int c = 0; c < 4; c++) begin
      issue(24'hFE_0100, 0, 0, 1, 2'(c), 2'(3 - c), "R3 sweep A");
      drain();
      issue(24'h01_0100, 1, 0, (c % 2 == 0), 2'(3 - c), 2'(c), "R3 R4 sweep B");
      drain();
    end

    repeat (4) @(negedge clk);
    chk(q_ale.size() == 0, "R8 queue empty", q_ale.size(), 0);
    chk(seen == issued, "R1 all accepted", seen, issued);
    finish_up();
  end
endmodule